// File: doc/BRIEF.md
# Prioritized Multi-Processor Interrupt Router

This block keeps one shared 64-bit pending vector for up to four processors and turns it into a small set of interrupt pins for each processor. Software changes the pending vector through two write-only ports. Writing ones to the raise port sets those bits. Writing ones to the drop port removes them. Hardware sources also set bits. They are sampled every cycle while they are high, and each bit stays set until software drops it. Software can read the pending vector, but it cannot write it directly.

Each processor has its own 64-bit enable mask. The vectors that are both pending and enabled for a processor are grouped into five fixed priority levels, and each level drives one pin of that processor. Level 4 is the most urgent and carries the error vectors. Level 3 holds only the timer vector. Level 2 carries inter-processor requests together with general devices. Levels 1 and 0 carry general device vectors. All pins are registered.

Top module: `irq_router`

## Requirements
- R1: After reset the pending vector, every enable mask and every level pin read as zero.
- R2: A write to byte address 0x20 ORs the write data into the pending vector. The pending vector reads back at address 0x30 with the same cycle timing as a direct register read.
- R3: A write to byte address 0x28 removes from the pending vector every bit that is one in the write data. When a hardware source and a drop hit the same bit in the same cycle, the bit stays set.
- R4: Each hardware source input that is high at a clock edge sets its pending bit. The bit stays set after the source goes low, until a drop write removes it.
- R5: A write to address 0x30 leaves the pending vector unchanged.
- R6: The enable mask of processor n is read and written at byte address n*8, for n from 0 to 3. A write to one mask leaves the other masks unchanged.
- R7: Vector v belongs to level 0 for v in 0..15, to level 1 for 16..31, to level 2 for 32..49, to level 3 for v equal to 50, and to level 4 for 51..63.
- R8: Pin irq_lvl[n*5+L] is high exactly when some vector of level L is pending and enabled in the mask of processor n.
- R9: A pin reflects the pending vector and the masks as they stood one clock edge earlier. A pin is low in any cycle that follows an edge at which nothing was both pending and enabled.
- R10: Reads from any other address, and from addresses whose low three bits are not zero, return zero. Writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data for addr, combinational |
| hw_src | input | 64 | Hardware interrupt sources, one per vector |
| irq_lvl | output | 20 | Level pins, bit n*5+L is level L of processor n |

## Verification
The assertions check on every cycle the properties that hold regardless of stimulus. Raised bits appear in the pending vector, dropped bits leave it, and hardware bits set it. The pending vector holds when nothing touches it, an unaddressed mask holds its value, and a pin stays low after a cycle in which nothing was both pending and enabled. Only the bench scenarios can show the rest. These are the mapping of every one of the 64 vectors onto its level and onto the correct processor's pins, the address decode including the ignored and unmapped addresses, and the case where a hardware source wins over a drop on the same bit.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_N  = 64;
    localparam int LVL_N  = 5;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_RAISE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DROP  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h30;

    // priority level of one vector
    function automatic int level_of(input int vec);
        if (vec < 16)       return 0;
        else if (vec < 32)  return 1;
        else if (vec < 50)  return 2;
        else if (vec == 50) return 3;
        else                return 4;
    endfunction

    // all vectors of one level
    function automatic logic [VEC_N-1:0] level_bits(input int lvl);
        logic [VEC_N-1:0] m;
        m = '0;
        for (int b = 0; b < VEC_N; b++) begin
            if (level_of(b) == lvl) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_we,
    input  logic             drop_we,
    input  logic [VEC_N-1:0] wdata,
    input  logic [VEC_N-1:0] hw_src,
    output logic [VEC_N-1:0] pend
);

    typedef struct packed {
        logic [VEC_N-1:0] bits;
    } pend_reg_t;

    pend_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drop_we)  st_d.bits = st_d.bits & ~wdata;
        if (raise_we) st_d.bits = st_d.bits | wdata;
        st_d.bits = st_d.bits | hw_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise_we |=> ((pend & $past(wdata)) == $past(wdata))); // R2
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_we && !raise_we && ((wdata & hw_src) == '0)) |=> ((pend & $past(wdata)) == '0)); // R3
    AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_src != '0) |=> ((pend & $past(hw_src)) == $past(hw_src))); // R4
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_we && !drop_we && (hw_src == '0)) |=> $stable(pend)); // R5

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int SEL_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  logic [VEC_N-1:0]              wdata,
    output logic [NUM_CPU-1:0][VEC_N-1:0] masks
);

    typedef struct packed {
        logic [NUM_CPU-1:0][VEC_N-1:0] m;
    } mask_reg_t;

    mask_reg_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (we && (sel == SEL_W'(c))) mk_d.m[c] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign masks = mk_q.m;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (sel == SEL_W'(g))) |=> $stable(masks[g])); // R6
    end

endmodule

// File: rtl/irq_level_reduce.sv
module irq_level_reduce
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_N-1:0] pend,
    input  logic [VEC_N-1:0] mask,
    output logic [LVL_N-1:0] lvl
);

    typedef struct packed {
        logic [LVL_N-1:0] pins;
    } lvl_reg_t;

    lvl_reg_t lv_d, lv_q;
    logic [VEC_N-1:0] live;

    assign live = pend & mask;

    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        localparam logic [VEC_N-1:0] SPAN = level_bits(l);
        always_comb lv_d.pins[l] = |(live & SPAN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    assign lvl = lv_q.pins;

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) == '0) |=> (lvl == '0)); // R9
    AST_PIN_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != '0) |-> ($past(pend & mask) != '0)); // R8

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int SEL_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int PIN_W  = NUM_CPU * LVL_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [VEC_N-1:0]  hw_src,
    output logic [PIN_W-1:0]  irq_lvl
);

    logic                          mask_hit;
    logic [SEL_W-1:0]              mask_sel;
    logic [VEC_N-1:0]              pend;
    logic [NUM_CPU-1:0][VEC_N-1:0] masks;
    logic                          raise_we, drop_we;

    assign mask_hit = (addr[2:0] == 3'b000) &&
                      ({3'b000, addr[ADDR_W-1:3]} < ADDR_W'(NUM_CPU));
    assign mask_sel = addr[3 +: SEL_W];
    assign raise_we = wr_en && (addr == OFF_RAISE);
    assign drop_we  = wr_en && (addr == OFF_DROP);

    irq_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_we (raise_we),
        .drop_we  (drop_we),
        .wdata    (wr_data),
        .hw_src   (hw_src),
        .pend     (pend)
    );

    irq_mask_bank #(.NUM_CPU(NUM_CPU)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && mask_hit),
        .sel   (mask_sel),
        .wdata (wr_data),
        .masks (masks)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_level_reduce u_red (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend),
            .mask  (masks[c]),
            .lvl   (irq_lvl[c*LVL_N +: LVL_N])
        );
    end

    always_comb begin
        rd_data = '0;
        if (mask_hit)              rd_data = masks[mask_sel];
        else if (addr == OFF_PEND) rd_data = pend;
    end

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [63:0] hw_src = '0;
    logic [19:0] irq_lvl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .hw_src(hw_src), .irq_lvl(irq_lvl)
    );

    function automatic int lvl_of(input int v);
        return (v < 16) ? 0 : (v < 32) ? 1 : (v < 50) ? 2 : (v == 50) ? 3 : 4;
    endfunction

    function automatic logic [19:0] exp_pins(input logic [63:0] p, input logic [3:0][63:0] m);
        logic [19:0] e;
        e = '0;
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 64; v++)
                if (p[v] && m[c][v]) e[c*5 + lvl_of(v)] = 1'b1;
        return e;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    logic [63:0] r;
    logic [3:0][63:0] m;
    logic [63:0] bit_v;

    initial begin
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pins", {44'd0, irq_lvl}, 64'd0);
        rd(8'h30, r); chk("R1 pend", r, 64'd0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(c*8), r); chk("R1 mask", r, 64'd0);
        end

        // R7 R8 R2 R3 sweep across every vector
        for (int v = 0; v < 64; v++) begin
            bit_v = 64'd1 << v;
            m[0] = '1; m[1] = '0; m[2] = bit_v; m[3] = ~bit_v;
            for (int c = 0; c < 4; c++) wr(8'(c*8), m[c]);
            wr(8'h20, bit_v);
            rd(8'h30, r); chk("R2 raise", r, bit_v);
            @(negedge clk);
            chk("R7 R8 level map", {44'd0, irq_lvl}, {44'd0, exp_pins(bit_v, m)});
            wr(8'h28, bit_v);
            rd(8'h30, r); chk("R3 drop", r, 64'd0);
            @(negedge clk);
            chk("R9 pins fall", {44'd0, irq_lvl}, 64'd0);
        end

        // R6 readback and independence
        wr(8'h00, 64'hA5A5_0000_FFFF_1234);
        wr(8'h08, 64'h0F0F_0F0F_0F0F_0F0F);
        wr(8'h10, 64'h8000_0000_0000_0001);
        wr(8'h18, 64'h0004_0000_0000_0000);
        rd(8'h00, r); chk("R6 mask0", r, 64'hA5A5_0000_FFFF_1234);
        rd(8'h08, r); chk("R6 mask1", r, 64'h0F0F_0F0F_0F0F_0F0F);
        rd(8'h10, r); chk("R6 mask2", r, 64'h8000_0000_0000_0001);
        rd(8'h18, r); chk("R6 mask3", r, 64'h0004_0000_0000_0000);

        // R10 unmapped and misaligned writes ignored, read zero
        wr(8'h48, '1); wr(8'h01, '1); wr(8'h40, '1);
        rd(8'h48, r); chk("R10 unmapped read", r, 64'd0);
        rd(8'h01, r); chk("R10 misaligned read", r, 64'd0);
        rd(8'h00, r); chk("R10 mask0 untouched", r, 64'hA5A5_0000_FFFF_1234);
        rd(8'h30, r); chk("R10 pend untouched", r, 64'd0);

        // R5 status read-only
        wr(8'h30, '1);
        rd(8'h30, r); chk("R5 pend write ignored", r, 64'd0);
        rd(8'h20, r); chk("R10 raise port reads zero", r, 64'd0);

        // R4 hardware source sticky, R9 latency
        wr(8'h00, '1); wr(8'h08, '0); wr(8'h10, '0); wr(8'h18, '0);
        @(negedge clk);
        hw_src = 64'h0004_0000_0000_0000;
        @(negedge clk);
        hw_src = '0;
        chk("R9 pin not yet", {44'd0, irq_lvl}, 64'd0);
        rd(8'h30, r); chk("R4 hw sets", r, 64'h0004_0000_0000_0000);
        @(negedge clk);
        chk("R9 pin after one edge", {44'd0, irq_lvl}, 64'h8);
        rd(8'h30, r); chk("R4 sticky", r, 64'h0004_0000_0000_0000);

        // R3 hw beats drop on same bit
        @(negedge clk);
        hw_src = 64'h8000_0000_0000_0000;
        addr = 8'h28; wr_data = 64'h8004_0000_0000_0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; hw_src = '0;
        rd(8'h30, r); chk("R3 hw wins over drop", r, 64'h8000_0000_0000_0000);
        @(negedge clk);
        chk("R8 level4 cpu0", {44'd0, irq_lvl}, 64'h10);
        wr(8'h28, '1);
        rd(8'h30, r); chk("R3 drop all", r, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule